// File: doc/BRIEF.md
# Logic Self-Test Engine

This block tests a small circuit under test (CUT) without an external tester. A maximal-length pattern register drives a network of XOR taps. The taps feed several scan chains in parallel, and the bits the chains shift out are folded into one signature register. Each pattern is shifted in over the length of a chain and then captured in a single cycle. While the next pattern shifts in, the captured response shifts out.

After the programmed number of patterns, one last unload pass empties the chains. The signature is then compared once against a golden value held on chip. The result is a done flag together with either a pass or a fail flag.

A run can be started in three ways:
- a pulse on a pin;
- a write to a small test-port register window;
- automatically in the first cycle after reset, when the auto-start strap is high.

The same window holds the pattern count and the golden value, and it reports status and the current signature.

Top module: `lbist_engine`

## Requirements
- R1: The pattern register is a 16-bit right-shifting Galois LFSR with feedback mask 0xB400 (when bit 0 is 1, the shifted value is XORed with the mask). It is loaded with the non-zero seed 0xACE1 when a run starts and advances once per shift cycle only.
- R2: Chain input c is the XOR of pattern register bits c, (c+5) mod 16 and (c+11) mod 16, so the first shift cycle of a run presents this function of the seed.
- R3: Each pattern is 8 shift cycles with scan_en high and capture low, followed by one cycle with capture high and scan_en low. After P patterns one further 8-cycle unload pass follows, so busy is high for exactly 2 + 8(P+1) + P cycles.
- R4: The signature register starts from 0x1D0F. On each shift cycle of passes 1..P it becomes its right-shifted Galois step (mask 0xB400) XOR the chain outputs, with chain c on bit c. Pass 0 is not compacted, so a count of 0 leaves the signature at the seed.
- R5: The comparison happens once, after the final unload. done then rises with pass=1 if the signature, zero-extended to 32 bits, equals the golden register, and with fail=1 otherwise. pass and fail are never both high, and are low whenever done is low.
- R6: Register window, with read data registered one cycle after the address:
  - address 0: a write with bit 0 set requests a start; a read returns bit0 busy, bit1 done, bit2 pass, bit3 fail.
  - address 1: the 32-bit pattern count (reset 20).
  - address 2: the 32-bit golden value (reset 0).
  - address 3: the signature, read only.
- R7: A start request from the pin or the register while busy is ignored, and so are writes to addresses 1 and 2 while busy. The run length, the verdict and the stored values do not change.
- R8: If auto_start is high in the first cycle after reset, a run with the reset-value count and golden value begins at once; if it is low, the engine stays idle.
- R9: Repeated runs with the same count produce the same signature. A stuck-at-0 fault inside the CUT produces a fail against the fault-free golden value.
- R10: After reset, busy, done, pass, fail, scan_en and capture are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start pulse from a pin |
| auto_start | input | 1 | Strap: run once right after reset |
| reg_addr | input | 2 | Register window address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Verdict available |
| pass | output | 1 | Signature matched |
| fail | output | 1 | Signature mismatched |
| scan_en | output | 1 | Shift enable toward the CUT |
| capture | output | 1 | Capture pulse toward the CUT |
| scan_in | output | 4 | Chain inputs toward the CUT |
| scan_out | input | 4 | Chain outputs from the CUT |

## Verification
The assertions check the following on every cycle:
- shift and capture are never high together, and every capture is followed by a shift;
- busy holds through a run regardless of start requests, and the configuration stays frozen while busy;
- the pattern register never reaches zero;
- the signature register moves only when compaction is enabled;
- a verdict appears only straight after the comparison, and never as both pass and fail.

Only the bench scenarios can show the rest:
- the exact run length;
- the chain input values;
- the final signature against an independent model of the CUT;
- the fail verdict under an injected stuck-at fault;
- the auto-start behaviour after reset.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SHIFT,
    ST_CAPTURE,
    ST_COMPARE,
    ST_DONE
  } lbist_state_e;

  localparam int REG_CTRL   = 0;
  localparam int REG_COUNT  = 1;
  localparam int REG_GOLDEN = 2;
  localparam int REG_SIG    = 3;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int unsigned       W        = 16,
  parameter logic [W-1:0]      POLY     = 16'hB400,
  parameter logic [W-1:0]      SEED     = 16'hACE1,
  parameter int unsigned       N_CHAINS = 4,
  parameter int unsigned       TAP_A    = 5,
  parameter int unsigned       TAP_B    = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init,
  input  logic                adv,
  output logic [N_CHAINS-1:0] chain_in
);

  logic [W-1:0] pat_q;
  logic [W-1:0] pat_step;

  always_comb begin
    pat_step = {1'b0, pat_q[W-1:1]} ^ (pat_q[0] ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      pat_q <= SEED;
    end else if (adv) begin
      pat_q <= pat_step;
    end
  end

  // phase shifter: three taps per chain, spread across the register
  for (genvar c = 0; c < N_CHAINS; c++) begin : g_phase
    assign chain_in[c] = pat_q[c % W] ^ pat_q[(c + TAP_A) % W] ^ pat_q[(c + TAP_B) % W];
  end

  AST_PRPG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pat_q != '0);  // R1
  AST_PRPG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !init) |=> $stable(pat_q));  // R1

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1D0F,
  parameter int unsigned  N_IN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic            en,
  input  logic [N_IN-1:0] din,
  output logic [W-1:0]    sig
);

  logic [W-1:0] din_ext;
  logic [W-1:0] sig_step;

  always_comb begin
    din_ext = '0;
    din_ext[N_IN-1:0] = din;
    sig_step = ({1'b0, sig[W-1:1]} ^ (sig[0] ? POLY : '0)) ^ din_ext;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      sig <= SEED;
    end else if (en) begin
      sig <= sig_step;
    end
  end

  AST_MISR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !init) |=> $stable(sig));  // R4

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             auto_start,
  input  logic [CNT_W-1:0] pat_count,
  input  logic             match,
  output logic             prpg_init,
  output logic             prpg_adv,
  output logic             misr_init,
  output logic             misr_en,
  output logic             scan_en,
  output logic             capture,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail
);

  localparam int unsigned BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;

  lbist_state_e     state, state_n;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] pass_cnt;
  logic             boot_pending;
  logic             launch;
  logic             last_bit;

  assign launch   = start || (boot_pending && auto_start);
  assign last_bit = (bit_cnt == BIT_W'(CHAIN_LEN - 1));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (launch) state_n = ST_INIT;
      ST_INIT:          state_n = ST_SHIFT;
      ST_SHIFT:         if (last_bit) state_n = (pass_cnt == pat_count) ? ST_COMPARE : ST_CAPTURE;
      ST_CAPTURE:       state_n = ST_SHIFT;
      ST_COMPARE:       state_n = ST_DONE;
      default:          state_n = ST_IDLE;
    endcase
  end

  assign prpg_init = (state == ST_INIT);
  assign misr_init = (state == ST_INIT);
  assign prpg_adv  = (state == ST_SHIFT);
  assign misr_en   = (state == ST_SHIFT) && (pass_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      pass_cnt     <= '0;
      boot_pending <= 1'b1;
      scan_en      <= 1'b0;
      capture      <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      pass         <= 1'b0;
      fail         <= 1'b0;
    end else begin
      state        <= state_n;
      boot_pending <= 1'b0;
      scan_en      <= (state_n == ST_SHIFT);
      capture      <= (state_n == ST_CAPTURE);
      busy         <= (state_n == ST_INIT) || (state_n == ST_SHIFT) ||
                      (state_n == ST_CAPTURE) || (state_n == ST_COMPARE);
      done         <= (state_n == ST_DONE);
      bit_cnt      <= (state == ST_SHIFT && !last_bit) ? bit_cnt + 1'b1 : '0;
      if (state == ST_INIT) begin
        pass_cnt <= '0;
      end else if (state == ST_CAPTURE) begin
        pass_cnt <= pass_cnt + 1'b1;
      end
      if (state == ST_COMPARE) begin
        pass <= match;
        fail <= !match;
      end else if (state_n != ST_DONE) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end
    end
  end

  AST_SCAN_CAPTURE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(scan_en && capture));  // R3
  AST_CAPTURE_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    capture |=> scan_en);  // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_COMPARE) |=> busy);  // R7
  AST_INIT_ONLY_FROM_REST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT) |-> ($past(state) == ST_IDLE || $past(state) == ST_DONE));  // R7
  AST_DONE_AFTER_COMPARE: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(done)) |-> ($past(state) == ST_COMPARE));  // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));  // R5
  AST_VERDICT_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);  // R5

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
  import lbist_pkg::*;
#(
  parameter int unsigned         N_CHAINS     = 4,
  parameter int unsigned         CHAIN_LEN    = 8,
  parameter int unsigned         PRPG_W       = 16,
  parameter logic [PRPG_W-1:0]   PRPG_POLY    = 16'hB400,
  parameter logic [PRPG_W-1:0]   PRPG_SEED    = 16'hACE1,
  parameter int unsigned         PS_TAP_A     = 5,
  parameter int unsigned         PS_TAP_B     = 11,
  parameter int unsigned         MISR_W       = 16,
  parameter logic [MISR_W-1:0]   MISR_POLY    = 16'hB400,
  parameter logic [MISR_W-1:0]   MISR_SEED    = 16'h1D0F,
  parameter int unsigned         ADDR_W       = 2,
  parameter int unsigned         DATA_W       = 32,
  parameter logic [DATA_W-1:0]   DEF_PATTERNS = 32'd20,
  parameter logic [DATA_W-1:0]   DEF_GOLDEN   = 32'd0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic                auto_start,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                busy,
  output logic                done,
  output logic                pass,
  output logic                fail,
  output logic                scan_en,
  output logic                capture,
  output logic [N_CHAINS-1:0] scan_in,
  input  logic [N_CHAINS-1:0] scan_out
);

  localparam int unsigned CNT_W = DATA_W;

  logic [CNT_W-1:0]  pat_count_q;
  logic [DATA_W-1:0] golden_q;
  logic [MISR_W-1:0] sig;
  logic              prpg_init, prpg_adv, misr_init, misr_en;
  logic              start_cmd, cfg_we, match;

  assign start_cmd = start_req ||
                     (reg_wr && reg_addr == ADDR_W'(REG_CTRL) && reg_wdata[0]);
  assign cfg_we    = reg_wr && !busy;
  assign match     = (DATA_W'(sig) == golden_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_count_q <= DEF_PATTERNS;
      golden_q    <= DEF_GOLDEN;
    end else if (cfg_we) begin
      if (reg_addr == ADDR_W'(REG_COUNT))  pat_count_q <= reg_wdata;
      if (reg_addr == ADDR_W'(REG_GOLDEN)) golden_q    <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        ADDR_W'(REG_CTRL):   reg_rdata <= DATA_W'({fail, pass, done, busy});
        ADDR_W'(REG_COUNT):  reg_rdata <= pat_count_q;
        ADDR_W'(REG_GOLDEN): reg_rdata <= golden_q;
        default:             reg_rdata <= DATA_W'(sig);
      endcase
    end
  end

  lbist_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start_cmd),
    .auto_start (auto_start),
    .pat_count  (pat_count_q),
    .match      (match),
    .prpg_init  (prpg_init),
    .prpg_adv   (prpg_adv),
    .misr_init  (misr_init),
    .misr_en    (misr_en),
    .scan_en    (scan_en),
    .capture    (capture),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail)
  );

  lbist_prpg #(
    .W        (PRPG_W),
    .POLY     (PRPG_POLY),
    .SEED     (PRPG_SEED),
    .N_CHAINS (N_CHAINS),
    .TAP_A    (PS_TAP_A),
    .TAP_B    (PS_TAP_B)
  ) u_prpg (
    .clk      (clk),
    .rst      (rst),
    .init     (prpg_init),
    .adv      (prpg_adv),
    .chain_in (scan_in)
  );

  lbist_misr #(
    .W    (MISR_W),
    .POLY (MISR_POLY),
    .SEED (MISR_SEED),
    .N_IN (N_CHAINS)
  ) u_misr (
    .clk  (clk),
    .rst  (rst),
    .init (misr_init),
    .en   (misr_en),
    .din  (scan_out),
    .sig  (sig)
  );

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(pat_count_q) && $stable(golden_q)));  // R7

endmodule

// File: tb/lbist_engine_bench.sv
`timescale 1ns/1ps
module lbist_engine_bench;

  localparam int          NC    = 4;
  localparam int          CL    = 8;
  localparam int          TOT   = NC * CL;
  localparam logic [15:0] PPOLY = 16'hB400;
  localparam logic [15:0] PSEED = 16'hACE1;
  localparam logic [15:0] MPOLY = 16'hB400;
  localparam logic [15:0] MSEED = 16'h1D0F;
  localparam logic [31:0] DEFP  = 32'd20;
  localparam logic [31:0] DEFG  = 32'd0;
  localparam logic [TOT-1:0] FAULT_MASK = TOT'(1) << 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_req = 1'b0;
  logic          auto_start = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          busy, done, pass, fail, scan_en, capture;
  logic [NC-1:0] scan_in, scan_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  lbist_engine #(
    .N_CHAINS(NC), .CHAIN_LEN(CL), .PRPG_W(16), .PRPG_POLY(PPOLY), .PRPG_SEED(PSEED),
    .PS_TAP_A(5), .PS_TAP_B(11), .MISR_W(16), .MISR_POLY(MPOLY), .MISR_SEED(MSEED),
    .ADDR_W(2), .DATA_W(32), .DEF_PATTERNS(DEFP), .DEF_GOLDEN(DEFG)
  ) u_lbist_engine (
    .clk(clk), .rst(rst), .start_req(start_req), .auto_start(auto_start),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .scan_en(scan_en), .capture(capture), .scan_in(scan_in), .scan_out(scan_out)
  );

  // ---------------- reference functions ----------------
  function automatic logic [15:0] prpg_next(input logic [15:0] p);
    return {1'b0, p[15:1]} ^ (p[0] ? PPOLY : 16'h0);
  endfunction

  function automatic logic [15:0] misr_next(input logic [15:0] m, input logic [NC-1:0] d);
    return ({1'b0, m[15:1]} ^ (m[0] ? MPOLY : 16'h0)) ^ 16'(d);
  endfunction

  function automatic logic [NC-1:0] phase_out(input logic [15:0] p);
    logic [NC-1:0] o;
    for (int c = 0; c < NC; c++) o[c] = p[c % 16] ^ p[(c + 5) % 16] ^ p[(c + 11) % 16];
    return o;
  endfunction

  function automatic logic [TOT-1:0] cut_shift(input logic [TOT-1:0] s, input logic [NC-1:0] d);
    logic [TOT-1:0] r = s;
    for (int c = 0; c < NC; c++) begin
      for (int k = CL - 1; k > 0; k--) r[c*CL + k] = s[c*CL + k - 1];
      r[c*CL] = d[c];
    end
    return r;
  endfunction

  function automatic logic [TOT-1:0] cut_capture(input logic [TOT-1:0] s);
    logic [TOT-1:0] r;
    for (int i = 0; i < TOT; i++)
      r[i] = s[i] ^ (s[(i + 1) % TOT] & s[(i + 7) % TOT]) ^ s[(i + 13) % TOT];
    return r;
  endfunction

  function automatic logic [NC-1:0] cut_outs(input logic [TOT-1:0] s);
    logic [NC-1:0] o;
    for (int c = 0; c < NC; c++) o[c] = s[c*CL + CL - 1];
    return o;
  endfunction

  function automatic logic [15:0] model_sig(input int unsigned npat, input bit faulty);
    logic [15:0]    p = PSEED;
    logic [15:0]    m = MSEED;
    logic [TOT-1:0] s = '0;
    for (int unsigned ps = 0; ps <= npat; ps++) begin
      for (int b = 0; b < CL; b++) begin
        if (faulty) s = s & ~FAULT_MASK;
        if (ps > 0) m = misr_next(m, cut_outs(s));
        s = cut_shift(s, phase_out(p));
        p = prpg_next(p);
      end
      if (ps < npat) begin
        if (faulty) s = s & ~FAULT_MASK;
        s = cut_capture(s);
      end
    end
    return m;
  endfunction

  // ---------------- circuit under test model ----------------
  logic [TOT-1:0] cut_q;
  logic [TOT-1:0] cut_eff;
  logic           fault_en = 1'b0;

  always_comb begin
    cut_eff  = fault_en ? (cut_q & ~FAULT_MASK) : cut_q;
    scan_out = cut_outs(cut_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) cut_q <= '0;
    else if (scan_en) cut_q <= cut_shift(cut_eff, scan_in);
    else if (capture) cut_q <= cut_capture(cut_eff);
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // counts busy cycles from the current negedge until done; records the first two chain inputs
  task automatic watch_run(input bit poke, input logic [31:0] gold,
                           output int bcnt, output int scnt, output int ccnt,
                           output logic [NC-1:0] in0, output logic [NC-1:0] in1);
    int guard = 0;
    bcnt = 0; scnt = 0; ccnt = 0; in0 = '0; in1 = '0;
    while (!done && guard < 60000) begin
      if (busy) bcnt++;
      if (scan_en) begin
        if (scnt == 0) in0 = scan_in;
        if (scnt == 1) in1 = scan_in;
        scnt++;
      end
      if (capture) ccnt++;
      start_req = poke && (bcnt == 10);
      if (poke && bcnt == 12) begin
        reg_addr = 2'd2; reg_wdata = ~gold; reg_wr = 1'b1;
      end else if (poke && bcnt == 14) begin
        reg_addr = 2'd0; reg_wdata = 32'd1; reg_wr = 1'b1;
      end else begin
        reg_wr = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic run_case(input string tag, input int unsigned npat, input logic [31:0] gold,
                          input bit faulty, input bit use_pin, input bit poke,
                          output logic [15:0] sig_seen);
    int bcnt, scnt, ccnt;
    logic [NC-1:0] in0, in1;
    logic [15:0] exp_sig;
    logic        exp_pass;
    logic [31:0] rd;
    exp_sig  = model_sig(npat, faulty);
    exp_pass = (32'(exp_sig) == gold);
    fault_en = faulty;
    reg_write(2'd1, npat);
    reg_write(2'd2, gold);
    if (use_pin) begin
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
    end else begin
      reg_write(2'd0, 32'd1);
    end
    watch_run(poke, gold, bcnt, scnt, ccnt, in0, in1);
    chk("R3", {tag, " busy cycles"}, bcnt, 2 + (npat + 1) * CL + npat);
    chk("R3", {tag, " shift cycles"}, scnt, (npat + 1) * CL);
    chk("R3", {tag, " capture cycles"}, ccnt, npat);
    chk("R2", {tag, " first chain inputs"}, in0, phase_out(PSEED));
    chk("R1", {tag, " second chain inputs"}, in1, phase_out(prpg_next(PSEED)));
    chk("R5", {tag, " done"}, done, 1);
    chk("R5", {tag, " pass"}, pass, exp_pass);
    chk("R5", {tag, " fail"}, fail, !exp_pass);
    reg_read(2'd3, rd);
    sig_seen = rd[15:0];
    chk("R4", {tag, " signature"}, rd, 32'(exp_sig));
    reg_read(2'd0, rd);
    chk("R6", {tag, " status word"}, rd, {28'd0, !exp_pass, exp_pass, 1'b1, 1'b0});
    if (poke) begin
      reg_read(2'd2, rd);
      chk("R7", {tag, " golden kept while busy"}, rd, gold);
    end
    fault_en = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    logic [15:0] s_a, s_b, s_x;
    int          bcnt, scnt, ccnt;
    logic [NC-1:0] i0, i1;
    void'($urandom(32'd7031));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R10", "pass/fail after reset", {pass, fail}, 0);
    chk("R10", "scan_en/capture after reset", {scan_en, capture}, 0);
    chk("R8", "no auto-start when strap low", busy, 0);
    reg_read(2'd0, rd); chk("R6", "status after reset", rd, 0);
    reg_read(2'd1, rd); chk("R6", "count reset value", rd, DEFP);
    reg_read(2'd2, rd); chk("R6", "golden reset value", rd, DEFG);
    reg_write(2'd1, 32'd100000);
    reg_read(2'd1, rd); chk("R6", "count holds 100000", rd, 32'd100000);
    reg_write(2'd1, 32'h0001_FFFF);
    reg_read(2'd1, rd); chk("R6", "count holds 17-bit max", rd, 32'h0001_FFFF);

    // zero patterns: signature stays at seed
    run_case("zero-count", 0, 32'(MSEED), 1'b0, 1'b0, 1'b0, s_x);
    chk("R4", "zero count leaves seed", s_x, MSEED);
    run_case("one-pattern", 1, 32'(model_sig(1, 1'b0)), 1'b0, 1'b1, 1'b0, s_x);

    // determinism and fault detection
    run_case("repeat-a", 25, 32'(model_sig(25, 1'b0)), 1'b0, 1'b0, 1'b0, s_a);
    run_case("repeat-b", 25, 32'(model_sig(25, 1'b0)), 1'b0, 1'b1, 1'b0, s_b);
    chk("R9", "repeated runs identical", s_a, s_b);
    run_case("stuck-at", 25, 32'(model_sig(25, 1'b0)), 1'b1, 1'b0, 1'b0, s_x);
    chk("R9", "fault yields fail", fail, 1);
    run_case("long-faulty", 500, 32'(model_sig(500, 1'b0)), 1'b1, 1'b0, 1'b0, s_x);
    chk("R9", "long fault run flagged", {pass, fail}, 2'b01);

    // starts and writes while busy are ignored
    run_case("poked", 12, 32'(model_sig(12, 1'b0)), 1'b0, 1'b0, 1'b1, s_x);

    // golden value with upper bits set never matches
    run_case("wide-golden", 3, 32'(model_sig(3, 1'b0)) | 32'h0001_0000, 1'b0, 1'b0, 1'b0, s_x);

    // constrained random runs
    for (int n = 0; n < 6; n++) begin
      int unsigned np = 1 + ($urandom % 30);
      logic [31:0] g = 32'(model_sig(np, 1'b0));
      bit good = ($urandom % 2) == 1;
      bit pin  = ($urandom % 2) == 1;
      if (!good) g = g ^ (32'd1 + ($urandom % 32'd65535));
      run_case("random", np, g, 1'b0, pin, ($urandom % 3) == 0, s_x);
    end

    // auto-start after reset with default configuration
    @(negedge clk);
    rst = 1'b1; auto_start = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "auto-start raises busy", busy, 1);
    watch_run(1'b0, 32'd0, bcnt, scnt, ccnt, i0, i1);
    auto_start = 1'b0;
    chk("R8", "auto-start run length", bcnt, 2 + (DEFP + 1) * CL + DEFP);
    chk("R8", "auto-start verdict", pass, (32'(model_sig(DEFP, 1'b0)) == DEFG));
    reg_read(2'd3, rd);
    chk("R8", "auto-start signature", rd, 32'(model_sig(DEFP, 1'b0)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule